// File: doc/BRIEF.md
# Cache ECC Error Reporting Unit

This block is the error-reporting front end of a shared cache controller. The cache pipeline signals ECC events as single-cycle pulses, and each pulse carries the 64-bit address of the failing access. The unit sorts events into four classes: directory corrected, data corrected, data uncorrectable and directory uncorrectable. For each class it keeps the most recent failing address, a saturating event count and a dedicated interrupt line.

Software talks to the unit through a simple 32-bit register port. The read data is combinational from the current state, and read and write strobes act on the next clock edge. The same port also exposes a read-only geometry word and a way-enable register that holds the index of the largest enabled way. A third register starts error injection: an accepted injection code becomes a one-cycle pulse toward the array ECC logic, and the register then clears itself.

Top module: `ecc_err_report`

## Requirements
- R1: After reset, every interrupt line and the inject pulse are low. Every class register reads 0, the inject register at 0x40 reads 0, and the way-enable register at 0x08 reads WAYS-1.
- R2: The word at offset 0x00 reads {log2 bytes per block, log2 sets per bank, ways per bank, banks}, with one 8-bit field each and the bank count in bits [7:0].
- R3: An event stores its 64-bit address for its class. Address bits [31:0] read at base+0x0 and bits [63:32] at base+0x4. The bases are 0x100 (directory corrected), 0x140 (data corrected), 0x160 (data uncorrectable) and 0x120 (directory uncorrectable).
- R4: The count at base+0x8 increases by one on each event of its class and saturates at its all-ones value (a CNT_W-bit counter, zero-extended to 32 bits).
- R5: An event sets the interrupt of its class on the next edge. The interrupt indices are 0 directory corrected, 1 data corrected, 2 data uncorrectable and 3 directory uncorrectable.
- R6: A read of a class's count register clears that class's interrupt. Reads of its address registers leave the interrupt set.
- R7: If an event and a count read of the same class fall in the same cycle, the interrupt stays set, the read returns the old count, and the count still increments.
- R8: A write to 0x08 with a value no greater than WAYS-1 updates the way-enable register. A larger value is ignored.
- R9: A write to 0x40 of a value in 0x00..0xFE or 0x10000..0x100FE produces, on the next edge, a one-cycle pulse on inj_vld_o. inj_dir_o carries value bit 16 (1 = directory, 0 = data) and inj_bit_o carries value bits [7:0]. After the pulse, 0x40 reads 0.
- R10: A write to 0x40 outside those ranges produces no pulse.
- R11: Unmapped offsets read 0. Writes to the geometry word and to the class registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_vld_i | input | 4 | Event pulse per class, in interrupt index order |
| evt_addr_i | input | 4x64 | Failing address per class |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects only) |
| reg_off_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_off_i |
| irq_o | output | 4 | Per-class interrupt lines |
| inj_vld_o | output | 1 | One-cycle inject request |
| inj_dir_o | output | 1 | Inject target: 1 directory, 0 data |
| inj_bit_o | output | 8 | Bit index to flip |

## Verification
The count-register read that clears an interrupt can fall in the same cycle as a new event of that class. The bench provokes this by raising the data-corrected event pulse in the very cycle it reads offset 0x148. It then judges the result three ways: the read must return the count from before the event, the interrupt line must still be high one edge later, and a second read must show the incremented count before the line finally drops.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  localparam int unsigned NUM_CLS = 4;
  localparam int unsigned OFF_W   = 12;

  typedef enum logic [1:0] {
    CLS_DIR_FIX  = 2'd0,
    CLS_DAT_FIX  = 2'd1,
    CLS_DAT_FAIL = 2'd2,
    CLS_DIR_FAIL = 2'd3
  } ecc_cls_e;

  localparam logic [OFF_W-1:0] OFF_CFG   = 12'h000;
  localparam logic [OFF_W-1:0] OFF_WAYEN = 12'h008;
  localparam logic [OFF_W-1:0] OFF_INJ   = 12'h040;

  // register window per class, indexed by interrupt order
  function automatic logic [OFF_W-1:0] cls_base(int unsigned idx);
    case (idx)
      0:       return 12'h100;
      1:       return 12'h140;
      2:       return 12'h160;
      default: return 12'h120;
    endcase
  endfunction

  function automatic logic inj_code_ok(logic [31:0] v);
    return (v <= 32'h0000_00FE) || (v >= 32'h0001_0000 && v <= 32'h0001_00FE);
  endfunction
endpackage

// File: rtl/ecc_cls_rec.sv
module ecc_cls_rec
  import ecc_rpt_pkg::*;
#(
  parameter int unsigned      EA_W  = 64,
  parameter int unsigned      CNT_W = 32,
  parameter logic [OFF_W-1:0] BASE  = 12'h100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [EA_W-1:0]  evt_addr_i,
  input  logic             rd_en_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [EA_W-1:0]  addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             sel_lo, sel_hi, sel_cnt;

  assign sel_lo  = (rd_off_i == BASE);
  assign sel_hi  = (rd_off_i == BASE + 12'h4);
  assign sel_cnt = (rd_off_i == BASE + 12'h8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (evt_i) begin
      addr_q <= evt_addr_i;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // new event wins over a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 irq_q <= 1'b0;
    else if (evt_i)              irq_q <= 1'b1;
    else if (rd_en_i && sel_cnt) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (sel_lo)       rdata_o = addr_q[31:0];
    else if (sel_hi)  rdata_o = 32'(addr_q[EA_W-1:32]);
    else if (sel_cnt) rdata_o = 32'(cnt_q);
  end

  a_r3_addr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> addr_q == $past(evt_addr_i));
  a_r4_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r4_cnt_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  a_r5_irq_on_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> irq_o);
  a_r6_cnt_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_cnt && !evt_i) |=> !irq_o);
  a_r6_addr_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && rd_en_i && (sel_lo || sel_hi)) |=> irq_o);
  a_r7_evt_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && rd_en_i && sel_cnt) |=> irq_o);
endmodule

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
  import ecc_rpt_pkg::*;
#(
  parameter int unsigned BANKS     = 4,
  parameter int unsigned WAYS      = 16,
  parameter int unsigned LOG2_SETS = 10,
  parameter int unsigned LOG2_BLK  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  localparam logic [7:0]  WAY_MAX  = 8'(WAYS - 1);
  localparam logic [31:0] CFG_WORD = {8'(LOG2_BLK), 8'(LOG2_SETS), 8'(WAYS), 8'(BANKS)};

  logic [7:0] wayen_q;
  logic       wr_way;

  assign wr_way = we_i && (off_i == OFF_WAYEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    wayen_q <= WAY_MAX;
    else if (wr_way && wdata_i <= 32'(WAY_MAX))     wayen_q <= wdata_i[7:0];
  end

  always_comb begin
    rdata_o = '0;
    if (off_i == OFF_CFG)        rdata_o = CFG_WORD;
    else if (off_i == OFF_WAYEN) rdata_o = {24'd0, wayen_q};
  end

  a_r8_wayen_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_way && wdata_i > 32'(WAY_MAX)) |=> $stable(wayen_q));
  a_r8_wayen_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_way && wdata_i <= 32'(WAY_MAX)) |=> wayen_q == $past(wdata_i[7:0]));
endmodule

// File: rtl/ecc_inj_ctl.sv
module ecc_inj_ctl
  import ecc_rpt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic        vld_o,
  output logic        dir_o,
  output logic [7:0]  bit_o,
  output logic [31:0] val_o
);
  logic [31:0] inj_q;
  logic        vld_q;
  logic        take;

  assign take = wr_en_i && inj_code_ok(wdata_i);

  // register self-clears one cycle after an accepted write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inj_q <= '0;
      vld_q <= 1'b0;
    end else if (take) begin
      inj_q <= wdata_i;
      vld_q <= 1'b1;
    end else begin
      inj_q <= '0;
      vld_q <= 1'b0;
    end
  end

  assign vld_o = vld_q;
  assign dir_o = vld_q & inj_q[16];
  assign bit_o = vld_q ? inj_q[7:0] : 8'd0;
  assign val_o = inj_q;

  a_r9_pulse_on_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (vld_o && bit_o == $past(wdata_i[7:0]) && dir_o == $past(wdata_i[16])));
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !take) |=> !vld_o);
  a_r10_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !inj_code_ok(wdata_i)) |=> !vld_o);
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
  import ecc_rpt_pkg::*;
#(
  parameter int unsigned BANKS     = 4,
  parameter int unsigned WAYS      = 16,
  parameter int unsigned LOG2_SETS = 10,
  parameter int unsigned LOG2_BLK  = 6,
  parameter int unsigned EA_W      = 64,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_CLS-1:0]              evt_vld_i,
  input  logic [NUM_CLS-1:0][EA_W-1:0]    evt_addr_i,
  input  logic                            reg_we_i,
  input  logic                            reg_re_i,
  input  logic [OFF_W-1:0]                reg_off_i,
  input  logic [31:0]                     reg_wdata_i,
  output logic [31:0]                     reg_rdata_o,
  output logic [NUM_CLS-1:0]              irq_o,
  output logic                            inj_vld_o,
  output logic                            inj_dir_o,
  output logic [7:0]                      inj_bit_o
);
  logic [NUM_CLS-1:0][31:0] cls_rdata;
  logic [31:0]              cfg_rdata;
  logic [31:0]              inj_val;

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
    ecc_cls_rec #(
      .EA_W (EA_W),
      .CNT_W(CNT_W),
      .BASE (cls_base(i))
    ) u_rec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_vld_i[i]),
      .evt_addr_i(evt_addr_i[i]),
      .rd_en_i   (reg_re_i),
      .rd_off_i  (reg_off_i),
      .rdata_o   (cls_rdata[i]),
      .irq_o     (irq_o[i])
    );
  end

  ecc_cfg_regs #(
    .BANKS    (BANKS),
    .WAYS     (WAYS),
    .LOG2_SETS(LOG2_SETS),
    .LOG2_BLK (LOG2_BLK)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .off_i  (reg_off_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(cfg_rdata)
  );

  ecc_inj_ctl u_inj (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(reg_we_i && reg_off_i == OFF_INJ),
    .wdata_i(reg_wdata_i),
    .vld_o  (inj_vld_o),
    .dir_o  (inj_dir_o),
    .bit_o  (inj_bit_o),
    .val_o  (inj_val)
  );

  // each source returns zero when its offset does not match
  always_comb begin
    reg_rdata_o = cfg_rdata;
    if (reg_off_i == OFF_INJ) reg_rdata_o = inj_val;
    for (int i = 0; i < NUM_CLS; i++) reg_rdata_o = reg_rdata_o | cls_rdata[i];
  end

  a_r5_irq_low_without_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o[0]) |-> $past(evt_vld_i[0])));
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_off_i[1:0] != 2'b00) |-> reg_rdata_o == 32'd0);
endmodule

// File: tb/tb_ecc_err_report.sv
module tb_ecc_err_report;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       evt_vld = '0;
  logic [3:0][63:0] evt_addr = '0;
  logic             reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0]      reg_off = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [3:0]       irq;
  logic             inj_vld, inj_dir;
  logic [7:0]       inj_bit;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    logic [11:0] off;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];
  rd_item_t cur;

  always #5 clk = ~clk;

  ecc_err_report #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_vld_i(evt_vld), .evt_addr_i(evt_addr),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_off_i(reg_off),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .inj_vld_o(inj_vld), .inj_dir_o(inj_dir), .inj_bit_o(inj_bit)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data in the middle of each read cycle
  always @(negedge clk) begin
    if (reg_re && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      chk(reg_rdata === cur.exp, cur.tag, 64'(reg_rdata), 64'(cur.exp));
    end
  end

  task automatic rd(logic [11:0] off, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    reg_re = 1'b1; reg_off = off;
    exp_q.push_back('{exp: exp, off: off, tag: tag});
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic wr(logic [11:0] off, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_off = off; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic fire(int cls, logic [63:0] a);
    @(posedge clk); #1;
    evt_vld[cls] = 1'b1; evt_addr[cls] = a;
    @(posedge clk); #1;
    evt_vld = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(irq == 4'd0, "R1 irq", 64'(irq), 0);
    chk(inj_vld == 1'b0, "R1 inj", 64'(inj_vld), 0);
    rd(12'h108, 0, "R1 count");
    rd(12'h040, 0, "R1 inject");
    rd(12'h008, 32'd15, "R1 wayen");
    // R2 geometry word
    rd(12'h000, 32'h060A_1004, "R2 config");
    // R11 unmapped
    rd(12'h200, 0, "R11 unmapped");
    rd(12'h101, 0, "R11 unaligned");

    // R3 R5 R6 directory corrected, index 0
    fire(0, 64'h1234_5678_9ABC_DEF0);
    chk(irq == 4'b0001, "R5 irq0", 64'(irq), 1);
    rd(12'h100, 32'h9ABC_DEF0, "R3 dirfix lo");
    rd(12'h104, 32'h1234_5678, "R3 dirfix hi");
    chk(irq[0] == 1'b1, "R6 addr read keeps irq", 64'(irq[0]), 1);
    rd(12'h108, 1, "R4 dirfix count");
    chk(irq[0] == 1'b0, "R6 count read clears", 64'(irq[0]), 0);

    // data corrected, index 1
    fire(1, 64'hAAAA_0001_BBBB_0002);
    chk(irq == 4'b0010, "R5 irq1", 64'(irq), 2);
    rd(12'h140, 32'hBBBB_0002, "R3 datfix lo");
    rd(12'h144, 32'hAAAA_0001, "R3 datfix hi");
    rd(12'h148, 1, "R4 datfix count");
    chk(irq[1] == 1'b0, "R6 irq1 clear", 64'(irq[1]), 0);

    // data uncorrectable, index 2
    fire(2, 64'h0000_0003_0000_0004);
    chk(irq == 4'b0100, "R5 irq2", 64'(irq), 4);
    rd(12'h160, 32'h0000_0004, "R3 datfail lo");
    rd(12'h164, 32'h0000_0003, "R3 datfail hi");

    // directory uncorrectable, index 3
    fire(3, 64'hFEED_0000_C0DE_0000);
    chk(irq == 4'b1100, "R5 irq3", 64'(irq), 12);
    rd(12'h120, 32'hC0DE_0000, "R3 dirfail lo");
    rd(12'h124, 32'hFEED_0000, "R3 dirfail hi");
    rd(12'h128, 1, "R4 dirfail count");
    chk(irq == 4'b0100, "R6 irq3 clear only", 64'(irq), 4);

    // R7 event and clearing read in the same cycle
    fire(1, 64'h10);
    @(posedge clk); #1;
    reg_re = 1'b1; reg_off = 12'h148;
    evt_vld[1] = 1'b1; evt_addr[1] = 64'h20;
    exp_q.push_back('{exp: 32'd2, off: 12'h148, tag: "R7 old count"});
    @(posedge clk); #1;
    reg_re = 1'b0; evt_vld = '0;
    chk(irq[1] == 1'b1, "R7 irq kept", 64'(irq[1]), 1);
    rd(12'h148, 3, "R7 count incremented");
    rd(12'h140, 32'h20, "R7 latest addr");
    chk(irq[1] == 1'b0, "R7 later clear", 64'(irq[1]), 0);

    // R4 saturation (4-bit counter)
    for (int k = 0; k < 20; k++) fire(2, 64'(k));
    rd(12'h168, 15, "R4 saturate");
    rd(12'h160, 32'd19, "R3 last addr");

    // R8 way-enable
    wr(12'h008, 32'd5);
    rd(12'h008, 5, "R8 wayen write");
    wr(12'h008, 32'd200);
    rd(12'h008, 5, "R8 wayen ignore big");

    // R11 writes to read-only registers
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h060A_1004, "R11 config ro");
    wr(12'h100, 32'h5555_5555);
    wr(12'h108, 32'h0);
    rd(12'h100, 32'h9ABC_DEF0, "R11 addr ro");
    rd(12'h108, 1, "R11 count ro");

    // R9 injection accepted
    wr(12'h040, 32'h0001_0005);
    chk(inj_vld && inj_dir && inj_bit == 8'd5, "R9 dir pulse",
        64'({inj_vld, inj_dir, inj_bit}), 64'h305);
    @(posedge clk); #1;
    chk(inj_vld == 1'b0, "R9 single pulse", 64'(inj_vld), 0);
    rd(12'h040, 0, "R9 self clear");
    wr(12'h040, 32'h0000_00FE);
    chk(inj_vld && !inj_dir && inj_bit == 8'hFE, "R9 data pulse",
        64'({inj_vld, inj_dir, inj_bit}), 64'h2FE);

    // R10 rejected codes
    wr(12'h040, 32'h0000_00FF);
    chk(inj_vld == 1'b0, "R10 reject FF", 64'(inj_vld), 0);
    wr(12'h040, 32'h0001_00FF);
    chk(inj_vld == 1'b0, "R10 reject 100FF", 64'(inj_vld), 0);
    wr(12'h040, 32'h0002_0000);
    chk(inj_vld == 1'b0, "R10 reject 20000", 64'(inj_vld), 0);

    repeat (2) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule